// File: doc/BRIEF.md
# Working Register File with Pointer Pairs

This block is the 32 x 8-bit general working register store of a small 8-bit RISC core. It feeds an ALU with two byte operands at once and accepts a byte result. It also has a 16-bit path that reads and writes aligned register pairs, so the core can fetch a 16-bit operand or write back a 16-bit result, such as a stepped pointer, in one cycle. All reads are combinational. All writes land on the next rising clock edge, so a two-operand read and the matching result write fit in one cycle.

The top six registers make up three 16-bit address pointers: X from registers 26/27, Y from 28/29 and Z from 30/31. Each pointer is always driven on its own output, with the low byte in the even register. Z is driven a second time on a separate program-memory lookup address output. The file is also mapped into the bottom of data space, so register n answers at data address n. The core's load/store path can reach it there with a byte read and a byte write.

Top module: `wreg_file`

## Requirements
- R1: After reset every one of the 32 registers reads as zero on every read path.
- R2: The two byte read ports return the register selected by their own address, combinationally and independently of each other.
- R3: A byte write with `wr_en` high stores `wr_data` into register `wr_addr` at the next rising edge. A read of that register in the same cycle returns the old value.
- R4: A pair write with `pr_wr_en` high and pair index p stores `pr_wr_data[7:0]` into register 2p and `pr_wr_data[15:8]` into register 2p+1 on the same edge. The pair read of index p returns {reg[2p+1], reg[2p]}.
- R5: `ptr_x` = {reg27, reg26}, `ptr_y` = {reg29, reg28}, `ptr_z` = {reg31, reg30} at all times. `lut_addr` always equals `ptr_z`.
- R6: When several write sources target the same register in one cycle, the pair write wins over the byte write, and the byte write wins over the data-space write. Sources that target different registers all take effect.
- R7: For a data address below 32, `ds_hit` is 1 and `ds_rdata` returns register n. With `ds_we` high, `ds_wdata` is stored into register n at the next edge.
- R8: For a data address of 32 or more, `ds_hit` and `ds_rdata` are 0, and a data-space write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_addr | input | 5 | Operand A register index |
| rd_a_data | output | 8 | Operand A value |
| rd_b_addr | input | 5 | Operand B register index |
| rd_b_data | output | 8 | Operand B value |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write value |
| pr_rd_idx | input | 4 | Pair read index (registers 2p, 2p+1) |
| pr_rd_data | output | 16 | Pair read value, high byte from odd register |
| pr_wr_en | input | 1 | Pair write enable |
| pr_wr_idx | input | 4 | Pair write index |
| pr_wr_data | input | 16 | Pair write value |
| ds_addr | input | 16 | Data-space address |
| ds_we | input | 1 | Data-space write enable |
| ds_wdata | input | 8 | Data-space write value |
| ds_hit | output | 1 | Data address falls on a register |
| ds_rdata | output | 8 | Data-space read value (0 on a miss) |
| ptr_x | output | 16 | X pointer |
| ptr_y | output | 16 | Y pointer |
| ptr_z | output | 16 | Z pointer |
| lut_addr | output | 16 | Program-memory lookup address (Z) |

## Verification
The bench first sweeps every register with a byte write while port A reads the same register. This separates a correct old-value read from a write-through design, and a distinct value per register catches address decode slips. A sweep over all 16 pairs with unequal byte halves tells a swapped low/high byte apart from a correct one and shows each pointer tracking its pair. A collision sweep aims all three write sources at each register in turn, which pins the priority order. A data-space sweep past address 31 separates in-range hits from ignored misses. A long run of random mixed cycles, compared against an array model, exercises every access scheme together.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
  // index of the even register of pair p
  function automatic int unsigned pair_lo(input int unsigned p);
    return 2 * p;
  endfunction

  // true when a data-space address lands inside the register file
  function automatic logic ds_in_file(input logic [15:0] a, input int unsigned nregs);
    return 32'(a) < nregs;
  endfunction
endpackage

// File: rtl/wreg_wsel.sv
module wreg_wsel #(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  parameter int AW    = $clog2(NREGS),
  parameter int DSW   = 16
) (
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              pr_wr_en,
  input  logic [AW-2:0]     pr_wr_idx,
  input  logic [2*DW-1:0]   pr_wr_data,
  input  logic              ds_we,
  input  logic [DSW-1:0]    ds_addr,
  input  logic [DW-1:0]     ds_wdata,
  output logic              we_vec [NREGS],
  output logic [DW-1:0]     wd_vec [NREGS]
);
  import wreg_pkg::*;

  logic ds_ok;
  assign ds_ok = ds_we && ds_in_file(ds_addr, NREGS);

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    localparam logic [AW-1:0] RIDX = AW'(i);
    localparam logic [AW-2:0] PIDX = (AW-1)'(i / 2);
    localparam bit            ODD  = (i % 2) == 1;
    logic hit_pair, hit_byte, hit_ds;
    logic [DW-1:0] pair_byte;
    assign hit_pair  = pr_wr_en && (pr_wr_idx == PIDX);
    assign hit_byte  = wr_en && (wr_addr == RIDX);
    assign hit_ds    = ds_ok && (ds_addr[AW-1:0] == RIDX);
    assign pair_byte = ODD ? pr_wr_data[2*DW-1:DW] : pr_wr_data[DW-1:0];
    always_comb begin
      we_vec[i] = hit_pair || hit_byte || hit_ds;
      if (hit_pair)      wd_vec[i] = pair_byte;
      else if (hit_byte) wd_vec[i] = wr_data;
      else               wd_vec[i] = ds_wdata;
    end
  end
endmodule

// File: rtl/wreg_store.sv
module wreg_store #(
  parameter int NREGS = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_vec [NREGS],
  input  logic [DW-1:0] wd_vec [NREGS],
  output logic [DW-1:0] mem    [NREGS]
);
  for (genvar i = 0; i < NREGS; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mem[i] <= '0;
      else if (we_vec[i]) mem[i] <= wd_vec[i];
    end
  end
endmodule

// File: rtl/wreg_file.sv
module wreg_file #(
  parameter int NREGS    = 32,
  parameter int DW       = 8,
  parameter int DSW      = 16,
  parameter int PTR_BASE = 26,
  localparam int AW      = $clog2(NREGS),
  localparam int PW      = 2 * DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  rd_a_addr,
  output logic [DW-1:0]  rd_a_data,
  input  logic [AW-1:0]  rd_b_addr,
  output logic [DW-1:0]  rd_b_data,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-2:0]  pr_rd_idx,
  output logic [PW-1:0]  pr_rd_data,
  input  logic           pr_wr_en,
  input  logic [AW-2:0]  pr_wr_idx,
  input  logic [PW-1:0]  pr_wr_data,
  input  logic [DSW-1:0] ds_addr,
  input  logic           ds_we,
  input  logic [DW-1:0]  ds_wdata,
  output logic           ds_hit,
  output logic [DW-1:0]  ds_rdata,
  output logic [PW-1:0]  ptr_x,
  output logic [PW-1:0]  ptr_y,
  output logic [PW-1:0]  ptr_z,
  output logic [PW-1:0]  lut_addr
);
  import wreg_pkg::*;

  localparam int X_LO = PTR_BASE;
  localparam int Y_LO = PTR_BASE + 2;
  localparam int Z_LO = PTR_BASE + 4;

  logic          we_vec [NREGS];
  logic [DW-1:0] wd_vec [NREGS];
  logic [DW-1:0] mem    [NREGS];

  wreg_wsel #(.NREGS(NREGS), .DW(DW), .AW(AW), .DSW(DSW)) u_wsel (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pr_wr_en(pr_wr_en), .pr_wr_idx(pr_wr_idx), .pr_wr_data(pr_wr_data),
    .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
    .we_vec(we_vec), .wd_vec(wd_vec)
  );

  wreg_store #(.NREGS(NREGS), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we_vec(we_vec), .wd_vec(wd_vec), .mem(mem)
  );

  assign rd_a_data  = mem[rd_a_addr];
  assign rd_b_data  = mem[rd_b_addr];
  assign pr_rd_data = {mem[{pr_rd_idx, 1'b1}], mem[{pr_rd_idx, 1'b0}]};

  assign ptr_x    = {mem[X_LO + 1], mem[X_LO]};
  assign ptr_y    = {mem[Y_LO + 1], mem[Y_LO]};
  assign ptr_z    = {mem[Z_LO + 1], mem[Z_LO]};
  assign lut_addr = ptr_z;

  assign ds_hit   = ds_in_file(ds_addr, NREGS);
  assign ds_rdata = ds_hit ? mem[ds_addr[AW-1:0]] : '0;

  // named events for the assertions
  logic byte_alone, byte_vs_pair, pair_on_x;
  assign byte_vs_pair = wr_en && pr_wr_en && (wr_addr[AW-1:1] == pr_wr_idx);
  assign byte_alone   = wr_en && !byte_vs_pair;
  assign pair_on_x    = pr_wr_en && (32'(pr_wr_idx) == X_LO / 2);

  assert_byte_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_alone |=> mem[$past(wr_addr)] == $past(wr_data));

  assert_pair_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pr_wr_en |=> mem[{$past(pr_wr_idx), 1'b0}] == $past(pr_wr_data[DW-1:0]));

  assert_pair_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pr_wr_en |=> mem[{$past(pr_wr_idx), 1'b1}] == $past(pr_wr_data[PW-1:DW]));

  assert_pair_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vs_pair |=> mem[$past(wr_addr)] ==
      ($past(wr_addr[0]) ? $past(pr_wr_data[PW-1:DW]) : $past(pr_wr_data[DW-1:0])));

  assert_x_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_on_x |=> ptr_x == $past(pr_wr_data));

  assert_miss_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_hit |-> ds_rdata == '0);
endmodule

// File: tb/wreg_file_test.sv
`timescale 1ns/10ps
module wreg_file_test;
  logic clk = 0, rst_n = 0;
  logic [4:0] rd_a_addr = 0, rd_b_addr = 0, wr_addr = 0;
  logic [7:0] rd_a_data, rd_b_data, wr_data = 0, ds_wdata = 0, ds_rdata;
  logic wr_en = 0, pr_wr_en = 0, ds_we = 0, ds_hit;
  logic [3:0] pr_rd_idx = 0, pr_wr_idx = 0;
  logic [15:0] pr_rd_data, pr_wr_data = 0, ds_addr = 0;
  logic [15:0] ptr_x, ptr_y, ptr_z, lut_addr;

  always #2 clk = ~clk;

  wreg_file uut (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] model [32];
  logic [7:0] nxt [32];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // check every output against the model, then clock one write cycle
  task automatic cycle();
    #1;
    chk("R2/R3 port A", rd_a_data, model[rd_a_addr]);
    chk("R2/R3 port B", rd_b_data, model[rd_b_addr]);
    chk("R4 pair read", pr_rd_data, {model[2*pr_rd_idx+1], model[2*pr_rd_idx]});
    chk("R5 ptr_x", ptr_x, {model[27], model[26]});
    chk("R5 ptr_y", ptr_y, {model[29], model[28]});
    chk("R5 ptr_z", ptr_z, {model[31], model[30]});
    chk("R5 lut_addr", lut_addr, {model[31], model[30]});
    if (ds_addr < 32) begin
      chk("R7 ds_hit", 16'(ds_hit), 16'd1);
      chk("R7 ds_rdata", 16'(ds_rdata), 16'(model[ds_addr[4:0]]));
    end else begin
      chk("R8 ds_hit", 16'(ds_hit), 16'd0);
      chk("R8 ds_rdata", 16'(ds_rdata), 16'd0);
    end
    nxt = model;
    if (ds_we && ds_addr < 32) nxt[ds_addr[4:0]] = ds_wdata;
    if (wr_en) nxt[wr_addr] = wr_data;
    if (pr_wr_en) begin
      nxt[2*pr_wr_idx]   = pr_wr_data[7:0];
      nxt[2*pr_wr_idx+1] = pr_wr_data[15:8];
    end
    @(posedge clk);
    model = nxt;
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; pr_wr_en = 0; ds_we = 0;
  endtask

  // walk all registers through both byte ports within one low phase
  task automatic check_all(input string req);
    idle();
    for (int i = 0; i < 32; i++) begin
      rd_a_addr = 5'(i); rd_b_addr = 5'(31 - i);
      #0.05;
      chk(req, rd_a_data, model[i]);
      chk(req, rd_b_data, model[31 - i]);
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_all("R1 reset");
    cycle();

    // R3 byte-write sweep, reading the target in the same cycle
    for (int i = 0; i < 32; i++) begin
      idle(); wr_en = 1; wr_addr = 5'(i); wr_data = 8'(i * 7 + 3);
      rd_a_addr = 5'(i); rd_b_addr = 5'(i ^ 1);
      cycle();
    end
    check_all("R3 sweep");

    // R4/R5 pair-write sweep with unequal halves
    for (int p = 0; p < 16; p++) begin
      idle(); pr_wr_en = 1; pr_wr_idx = 4'(p);
      pr_wr_data = {8'(8'hA0 + p), 8'(8'h50 + 3 * p)};
      pr_rd_idx = 4'(p);
      cycle();
      idle(); cycle();
    end
    check_all("R4 sweep");

    // R6 collision sweep: all three sources on one register
    for (int i = 0; i < 32; i++) begin
      idle();
      pr_wr_en = 1; pr_wr_idx = 4'(i / 2); pr_wr_data = {8'(i + 8'h10), 8'(i + 8'h20)};
      wr_en = 1; wr_addr = 5'(i); wr_data = 8'h77;
      ds_we = 1; ds_addr = 16'(i); ds_wdata = 8'h33;
      cycle();
      idle(); ds_we = 1; ds_addr = 16'(i); ds_wdata = 8'h44;
      wr_en = 1; wr_addr = 5'(i); wr_data = 8'hC5;
      cycle();
      rd_a_addr = 5'(i); cycle();
    end
    check_all("R6 priority");

    // R7/R8 data-space sweep across and past the file
    for (int a = 0; a < 48; a++) begin
      idle(); ds_we = 1; ds_addr = 16'(a); ds_wdata = 8'(8'h90 ^ a);
      cycle();
    end
    ds_addr = 16'h8003; ds_we = 1; ds_wdata = 8'hEE; cycle();
    check_all("R8 miss ignored");

    // mixed random cycles covering all access schemes together
    for (int n = 0; n < 3000; n++) begin
      rd_a_addr  = 5'($urandom); rd_b_addr = 5'($urandom);
      pr_rd_idx  = 4'($urandom);
      wr_en      = 1'($urandom); wr_addr = 5'($urandom); wr_data = 8'($urandom);
      pr_wr_en   = 1'($urandom); pr_wr_idx = ($urandom % 4 == 0) ? 4'(13 + $urandom % 3) : 4'($urandom);
      pr_wr_data = 16'($urandom);
      ds_we      = 1'($urandom); ds_wdata = 8'($urandom);
      ds_addr    = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 40);
      cycle();
    end
    check_all("R2 random final");

    // reset mid-run clears everything again
    rst_n = 0; #1; rst_n = 1;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    @(negedge clk);
    check_all("R1 second reset");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule